// File: doc/BRIEF.md
# Two-Phase Self-Test Sequencer

This block runs an on-chip self-test of a datapath built from three registers and the combinational logic that sits between them. The first logic block feeds the middle register and the last register. The second logic block takes its inputs from the first register and feeds the last register. The third logic block takes its inputs from the middle register and also feeds the last register. A single test pin chooses what the datapath does. While the pin is low, every register keeps its functional role and each input multiplexer passes functional data. While the pin is high, the sequencer walks through a fixed two-phase schedule. It drives a two-bit role code to each register and a select bit to each block's input multiplexer.

The test runs in two phases. In phase one, the first register generates pseudo-random patterns. Those patterns drive the first and second logic blocks in the same cycles, and the middle and last registers each compact the response of one block. In phase two, the roles move along the datapath. The middle register becomes the generator for the third logic block, and the last register compacts its response. Before each phase there is one initialisation cycle. In that cycle the generating register loads a nonzero seed, which the sequencer supplies, and the compacting registers are cleared.

The sequencer never inspects individual responses. After each phase it compares the finished signatures with good values fixed at build time. At the end it raises a done flag with a single pass or fail bit. Both stay up until the test pin is lowered.

Top module: `bist_seq_ctrl`

## Requirements
- R1: While reset is high, and in the cycle after reset is released with the test pin low, every role output is 0 (functional), `cut_sel_o` is 0, `seed_o` is 0, and `done_o` and `pass_o` are 0.
- R2: One clock edge after `test_en` is sampled low, in any state, all role outputs are 0, `cut_sel_o` is 0, `seed_o` is 0 and `done_o` is 0. A test that has been abandoned leaves no fail memory behind for the next test.
- R3: One edge after `test_en` is sampled high in the idle state, there is exactly one initialisation cycle for phase one. In that cycle all three role outputs are 3 (load seed / clear), `seed_o` equals `SEED_P1`, and `cut_sel_o` is 3'b011. Bit 0 of `cut_sel_o` selects the first block, bit 1 the second, bit 2 the third.
- R4: Phase one lasts exactly `N_PAT` cycles. In each of them `r1_mode_o` is 1 (generate), `r2_mode_o` and `r3_mode_o` are 2 (compact), `cut_sel_o` is 3'b011 and `seed_o` is 0.
- R5: Exactly one initialisation cycle for phase two follows. In it `r1_mode_o` is 0, `r2_mode_o` and `r3_mode_o` are 3, `seed_o` equals `SEED_P2`, and `cut_sel_o` is 3'b100.
- R6: Phase two lasts exactly `N_PAT` cycles. In each of them `r1_mode_o` is 0, `r2_mode_o` is 1, `r3_mode_o` is 2, `cut_sel_o` is 3'b100 and `seed_o` is 0.
- R7: The phase-one signatures are the values on `sig_mid_i` and `sig_last_i` during the phase-two initialisation cycle. They are compared with `GOOD_MID_P1` and `GOOD_LAST_P1`, and values in every other cycle are ignored.
- R8: The phase-two signature is the value on `sig_last_i` in the single compare cycle that follows phase two, compared with `GOOD_LAST_P2`. In that cycle all role outputs are 0 and `cut_sel_o` is 0.
- R9: `done_o` rises on the edge after the compare cycle. `pass_o` is then 1 exactly when all three signatures matched. Both stay constant while `test_en` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| test_en | input | 1 | Test pin: 0 functional, 1 run self-test |
| sig_mid_i | input | SIG_W | Current contents of the middle register |
| sig_last_i | input | SIG_W | Current contents of the last register |
| r1_mode_o | output | 2 | Role of the first register (0 func, 1 gen, 2 compact, 3 init) |
| r2_mode_o | output | 2 | Role of the middle register |
| r3_mode_o | output | 2 | Role of the last register |
| cut_sel_o | output | 3 | Per-block input multiplexer select, 1 = generated patterns |
| seed_o | output | SIG_W | Seed value offered to the generating register in init cycles |
| done_o | output | 1 | Test finished |
| pass_o | output | 1 | All signatures matched, valid with done_o |

## Verification
The bench sweeps all eight combinations of the three signature mismatches. A sequencer that lost the phase-one result when phase two began would report pass whenever only a phase-one mismatch was injected. The bench drives wrong values on the signature inputs in every cycle except the one in which each signature must be sampled. A comparison taken one cycle early or late therefore turns a good run into a fail. Every cycle's role codes and selects are checked against the schedule, so a phase counter off by one shows up as a wrong role in the first or last cycle of a phase. Aborts in the middle of phase one and phase two, each followed by a clean run, catch a fail flag that outlives the abort.

// File: rtl/bist_ctrl_pkg.sv
package bist_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SEED1 = 3'd1,
    ST_RUN1  = 3'd2,
    ST_SEED2 = 3'd3,
    ST_RUN2  = 3'd4,
    ST_CMP   = 3'd5,
    ST_DONE  = 3'd6
  } seq_state_t;

  typedef enum logic [1:0] {
    RM_FUNC = 2'd0,
    RM_GEN  = 2'd1,
    RM_COMP = 2'd2,
    RM_INIT = 2'd3
  } reg_role_t;

  localparam int unsigned NUM_CUT = 3;

endpackage

// File: rtl/bist_phase_cnt.sv
module bist_phase_cnt #(
  parameter int unsigned N_PAT = 10000
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic last
);
  localparam int unsigned CW = (N_PAT > 1) ? $clog2(N_PAT) : 1;
  localparam logic [CW-1:0] LAST_V = CW'(N_PAT - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run) cnt_q <= '0;
    else if (cnt_q != LAST_V) cnt_q <= cnt_q + 1'b1;
  end

  assign last = run && (cnt_q == LAST_V);

  // R4 / R6: the pattern counter never runs past the phase length
  a_r4_cnt_in_range: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST_V);

  // R4 / R6: the counter leaves zero only while a phase is running
  a_r6_cnt_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !$past(run) |-> cnt_q == '0);

endmodule

// File: rtl/bist_sig_chk.sv
module bist_sig_chk #(
  parameter int unsigned SIG_W = 16,
  parameter logic [SIG_W-1:0] GOOD_MID_P1  = '0,
  parameter logic [SIG_W-1:0] GOOD_LAST_P1 = '0,
  parameter logic [SIG_W-1:0] GOOD_LAST_P2 = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             chk_p1,
  input  logic             chk_p2,
  input  logic [SIG_W-1:0] sig_mid,
  input  logic [SIG_W-1:0] sig_last,
  output logic             bad_q,
  output logic             miss_p2
);
  logic miss_p1;

  assign miss_p1 = (sig_mid != GOOD_MID_P1) || (sig_last != GOOD_LAST_P1);
  assign miss_p2 = (sig_last != GOOD_LAST_P2);

  always_ff @(posedge clk) begin
    if (rst || clr)           bad_q <= 1'b0;
    else if (chk_p1 && miss_p1) bad_q <= 1'b1;
  end

  // R7: a phase-one miss seen in its sampling cycle is remembered
  a_r7_p1_sticky: assert property (@(posedge clk) disable iff (rst)
    (chk_p1 && miss_p1 && !clr) |=> bad_q);

  // R2: the fail memory is empty after an abort or idle cycle
  a_r2_clear: assert property (@(posedge clk) disable iff (rst)
    clr |=> !bad_q);

endmodule

// File: rtl/bist_mode_dec.sv
module bist_mode_dec
  import bist_ctrl_pkg::*;
#(
  parameter int unsigned SIG_W = 16,
  parameter logic [SIG_W-1:0] SEED_P1 = 1,
  parameter logic [SIG_W-1:0] SEED_P2 = 1
) (
  input  logic               clk,
  input  logic               rst,
  input  seq_state_t         nxt,
  output logic [1:0]         r1_mode,
  output logic [1:0]         r2_mode,
  output logic [1:0]         r3_mode,
  output logic [NUM_CUT-1:0] cut_sel,
  output logic [SIG_W-1:0]   seed,
  output logic               done
);
  reg_role_t          r1_d, r2_d, r3_d;
  logic [NUM_CUT-1:0] sel_d;
  logic [SIG_W-1:0]   seed_d;

  always_comb begin
    r1_d   = RM_FUNC;
    r2_d   = RM_FUNC;
    r3_d   = RM_FUNC;
    sel_d  = '0;
    seed_d = '0;
    unique case (nxt)
      ST_SEED1: begin
        r1_d = RM_INIT; r2_d = RM_INIT; r3_d = RM_INIT;
        sel_d = 3'b011; seed_d = SEED_P1;
      end
      ST_RUN1: begin
        r1_d = RM_GEN; r2_d = RM_COMP; r3_d = RM_COMP;
        sel_d = 3'b011;
      end
      ST_SEED2: begin
        r2_d = RM_INIT; r3_d = RM_INIT;
        sel_d = 3'b100; seed_d = SEED_P2;
      end
      ST_RUN2: begin
        r2_d = RM_GEN; r3_d = RM_COMP;
        sel_d = 3'b100;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      r1_mode <= RM_FUNC;
      r2_mode <= RM_FUNC;
      r3_mode <= RM_FUNC;
      cut_sel <= '0;
      seed    <= '0;
      done    <= 1'b0;
    end else begin
      r1_mode <= r1_d;
      r2_mode <= r2_d;
      r3_mode <= r3_d;
      cut_sel <= sel_d;
      seed    <= seed_d;
      done    <= (nxt == ST_DONE);
    end
  end

  // R4 / R6: at most one register generates patterns at a time
  a_r4_one_gen: assert property (@(posedge clk) disable iff (rst)
    $countones({r1_mode == RM_GEN, r2_mode == RM_GEN, r3_mode == RM_GEN}) <= 1);

  // R3 / R5: a seed is offered only while some register initialises
  a_r3_seed_in_init: assert property (@(posedge clk) disable iff (rst)
    (seed != '0) |-> (r2_mode == RM_INIT));

endmodule

// File: rtl/bist_seq_ctrl.sv
module bist_seq_ctrl
  import bist_ctrl_pkg::*;
#(
  parameter int unsigned N_PAT = 10000,
  parameter int unsigned SIG_W = 16,
  parameter logic [SIG_W-1:0] SEED_P1      = 16'h0001,
  parameter logic [SIG_W-1:0] SEED_P2      = 16'h8001,
  parameter logic [SIG_W-1:0] GOOD_MID_P1  = 16'h5A3C,
  parameter logic [SIG_W-1:0] GOOD_LAST_P1 = 16'hC0DE,
  parameter logic [SIG_W-1:0] GOOD_LAST_P2 = 16'h1F2E
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             test_en,
  input  logic [SIG_W-1:0] sig_mid_i,
  input  logic [SIG_W-1:0] sig_last_i,
  output logic [1:0]       r1_mode_o,
  output logic [1:0]       r2_mode_o,
  output logic [1:0]       r3_mode_o,
  output logic [2:0]       cut_sel_o,
  output logic [SIG_W-1:0] seed_o,
  output logic             done_o,
  output logic             pass_o
);
  seq_state_t state_q, state_d;
  logic       phase_last;
  logic       bad_q, miss_p2;
  logic       running;

  assign running = (state_q == ST_RUN1) || (state_q == ST_RUN2);

  bist_phase_cnt #(.N_PAT(N_PAT)) u_cnt (
    .clk  (clk),
    .rst  (rst),
    .run  (running),
    .last (phase_last)
  );

  bist_sig_chk #(
    .SIG_W        (SIG_W),
    .GOOD_MID_P1  (GOOD_MID_P1),
    .GOOD_LAST_P1 (GOOD_LAST_P1),
    .GOOD_LAST_P2 (GOOD_LAST_P2)
  ) u_chk (
    .clk      (clk),
    .rst      (rst),
    .clr      (state_q == ST_IDLE),
    .chk_p1   (state_q == ST_SEED2),
    .chk_p2   (state_q == ST_CMP),
    .sig_mid  (sig_mid_i),
    .sig_last (sig_last_i),
    .bad_q    (bad_q),
    .miss_p2  (miss_p2)
  );

  always_comb begin
    state_d = state_q;
    if (!test_en) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE:  state_d = ST_SEED1;
        ST_SEED1: state_d = ST_RUN1;
        ST_RUN1:  if (phase_last) state_d = ST_SEED2;
        ST_SEED2: state_d = ST_RUN2;
        ST_RUN2:  if (phase_last) state_d = ST_CMP;
        ST_CMP:   state_d = ST_DONE;
        ST_DONE:  state_d = ST_DONE;
        default:  state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end

  bist_mode_dec #(
    .SIG_W   (SIG_W),
    .SEED_P1 (SEED_P1),
    .SEED_P2 (SEED_P2)
  ) u_dec (
    .clk     (clk),
    .rst     (rst),
    .nxt     (state_d),
    .r1_mode (r1_mode_o),
    .r2_mode (r2_mode_o),
    .r3_mode (r3_mode_o),
    .cut_sel (cut_sel_o),
    .seed    (seed_o),
    .done    (done_o)
  );

  always_ff @(posedge clk) begin
    if (rst)                                  pass_o <= 1'b0;
    else if (state_q == ST_CMP && test_en)    pass_o <= !(bad_q || miss_p2);
    else if (state_d != ST_DONE)              pass_o <= 1'b0;
  end

  // R2: lowering the test pin returns the datapath to functional use
  a_r2_abort: assert property (@(posedge clk) disable iff (rst)
    !test_en |=> (!done_o && cut_sel_o == '0 && r2_mode_o == RM_FUNC));

  // R9: the result is held while the pin stays high
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    (done_o && test_en) |=> (done_o && $stable(pass_o)));

  // R9: pass is never reported without done
  a_r9_pass_needs_done: assert property (@(posedge clk) disable iff (rst)
    pass_o |-> done_o);

  // R8: done first appears right after the compare cycle
  a_r8_done_after_cmp: assert property (@(posedge clk) disable iff (rst)
    $rose(done_o) |-> $past(state_q == ST_CMP));

endmodule

// File: tb/bist_seq_ctrl_tb.sv
module bist_seq_ctrl_tb;
  localparam int unsigned NP = 5;
  localparam int unsigned SW = 8;
  localparam logic [SW-1:0] S1 = 8'h01, S2 = 8'h80;
  localparam logic [SW-1:0] GM = 8'hA5, GA = 8'h3C, GB = 8'hE1;

  logic clk = 1'b0, rst = 1'b1, test_en = 1'b0;
  logic [SW-1:0] sig_mid = '0, sig_last = '0;
  logic [1:0] r1m, r2m, r3m;
  logic [2:0] sel;
  logic [SW-1:0] seed;
  logic done, pass;
  int nchk = 0, nfail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  bist_seq_ctrl #(
    .N_PAT(NP), .SIG_W(SW), .SEED_P1(S1), .SEED_P2(S2),
    .GOOD_MID_P1(GM), .GOOD_LAST_P1(GA), .GOOD_LAST_P2(GB)
  ) u_dut (
    .clk(clk), .rst(rst), .test_en(test_en),
    .sig_mid_i(sig_mid), .sig_last_i(sig_last),
    .r1_mode_o(r1m), .r2_mode_o(r2m), .r3_mode_o(r3m),
    .cut_sel_o(sel), .seed_o(seed), .done_o(done), .pass_o(pass)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // phase: 0 idle, 1 seed1, 2 run1, 3 seed2, 4 run2, 5 compare, 6 done
  function automatic int ph_of(int i);
    if (i == 1) return 1;
    if (i <= NP + 1) return 2;
    if (i == NP + 2) return 3;
    if (i <= 2 * NP + 2) return 4;
    if (i == 2 * NP + 3) return 5;
    return 6;
  endfunction

  function automatic string req_of(int p);
    case (p)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3: return "R5";
      4: return "R6";
      5: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic chk_phase(int p);
    logic [1:0] e1, e2, e3;
    logic [2:0] es;
    logic [SW-1:0] ed;
    e1 = 0; e2 = 0; e3 = 0; es = 0; ed = 0;
    case (p)
      1: begin e1 = 3; e2 = 3; e3 = 3; es = 3'b011; ed = S1; end
      2: begin e1 = 1; e2 = 2; e3 = 2; es = 3'b011; end
      3: begin e2 = 3; e3 = 3; es = 3'b100; ed = S2; end
      4: begin e2 = 1; e3 = 2; es = 3'b100; end
      default: ;
    endcase
    chk(req_of(p), {r1m, r2m, r3m, sel}, {e1, e2, e3, es});
    chk(req_of(p), seed, ed);
    chk(req_of(p), done, (p == 6));
  endtask

  // drive signatures for the coming edge; wrong except in the sampling cycle
  task automatic drive_sig(int p, int f);
    sig_mid  = ~GM;
    sig_last = ~GA;
    if (p == 3) begin
      sig_mid  = f[0] ? (GM ^ 8'h01) : GM;
      sig_last = f[1] ? (GA ^ 8'h10) : GA;
    end else if (p == 5) begin
      sig_last = f[2] ? (GB ^ 8'h80) : GB;
    end
  endtask

  task automatic run_test(int f, int abort_at);
    @(posedge clk); #1;
    test_en = 1'b1;
    drive_sig(0, f);
    for (int i = 1; i <= 2 * NP + 7; i++) begin
      @(posedge clk); #1;
      chk_phase(ph_of(i));
      drive_sig(ph_of(i), f);
      if (i == abort_at) begin
        test_en = 1'b0;
        @(posedge clk); #1;
        chk_phase(0);                   // R2 abort
        chk("R2", pass, 0);
        return;
      end
    end
    chk("R9", pass, (f == 0));          // R7 / R8 outcome in R9 result
    test_en = 1'b0;
    @(posedge clk); #1;
    chk_phase(0);                       // R2 pin low
    chk("R2", pass, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk_phase(0);                       // R1 in reset
    chk("R1", pass, 0);
    rst = 1'b0;
    @(posedge clk); #1;
    chk_phase(0);                       // R1 after release
    chk("R1", pass, 0);
    for (int f = 0; f < 8; f++) run_test(f, 0);   // R7 R8 sweep
    run_test(7, 3);                     // abort inside phase one
    run_test(0, 0);                     // R2 clean after abort
    run_test(1, NP + 5);                // abort inside phase two
    run_test(0, 0);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog R9 actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule